// File: doc/BRIEF.md
# Serial Configuration Load Master

This block pushes a configuration image into a downstream programmable device one bit per clock. To start a load, it asserts the device's program request and waits for the device's init line to show that the device has entered initialisation. It then releases program and waits for init to clear. After that it takes bytes from a valid/ready stream and shifts each one out most significant bit first. The device samples each bit on the rising edge of the configuration clock. Once the last byte has gone out, the block holds the data line high and keeps pulsing the clock until the device raises done.

A command carries a byte count and a half-period divider for the configuration clock. Every wait is bounded by a timeout counted in system clock cycles. Before each byte the block checks for a load error: init active while done is still low. A readback command is refused, because readback is not available in serial mode. Each command ends with a one-cycle completion pulse and a status code.

Top module: `cfg_serial_loader`

## Requirements
- R1: Out of reset and whenever idle, program is released (cfg_prog_n=1), cfg_cclk is low, cfg_din is high, s_ready is low, busy is low and done_o is low.
- R2: On cmd_load, cfg_prog_n is driven low until cfg_init_n is seen low. If that does not happen within TMO_CYC cycles, the command ends with status 1 (init-start timeout).
- R3: After program is released, no cfg_cclk edge occurs until cfg_init_n is seen high. If cfg_init_n stays low for TMO_CYC cycles, the command ends with status 2 (init-clear timeout).
- R4: Each byte is sent most significant bit first, one bit per rising cfg_cclk edge. cfg_din changes only while cfg_cclk is low. Each clock phase lasts half_div+1 system cycles.
- R5: Before each byte is accepted, if cfg_init_n is low while cfg_done is low, the load stops with status 3 (CRC error) and no further byte is taken.
- R6: After the last byte, cfg_din is held high and cfg_cclk keeps pulsing. When cfg_done is seen high the status is 0 (success). If cfg_done stays low for TMO_CYC cycles the status is 4 (done timeout).
- R7: cmd_readback while idle ends at once with status 5 (unsupported), without touching the configuration pins. cmd_load takes priority when both are high.
- R8: Every command produces exactly one single-cycle done_o pulse. busy is high from the cycle after the command until that pulse.
- R9: A load with load_len=0 goes straight from init clear to the trailing clocks.
- R10: s_ready is high only while the block is waiting for the next byte, and never while cfg_cclk is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_load | input | 1 | Start a load (pulse while idle) |
| cmd_readback | input | 1 | Readback request (always refused) |
| load_len | input | CNT_W | Number of bytes to load |
| half_div | input | DIV_W | Configuration clock phase length minus one, in system cycles |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | BYTE_W | Stream byte |
| s_ready | output | 1 | Stream byte accepted this cycle when valid |
| cfg_prog_n | output | 1 | Program request to device, active low |
| cfg_cclk | output | 1 | Configuration clock |
| cfg_din | output | 1 | Serial configuration data |
| cfg_init_n | input | 1 | Device init status, active low |
| cfg_done | input | 1 | Device configuration done |
| busy | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle command completion pulse |
| status | output | 3 | Completion code, valid with done_o |

## Verification
A corrupted bit counter or shift register appears as a mismatched byte at the first rising clock edge after the bad byte's eighth bit. The device-side scoreboard catches this within one byte time. A sequencer stuck in the wrong phase shows up as a wrong status code on the completion pulse, as data changing while the clock is high, or as clock edges while program is asserted. Every one of these is visible at the pins at or before the end of the affected command. A broken timeout counter shows up as a missing or early completion pulse in the timeout scenarios, within one TMO_CYC window.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_REL, ST_FETCH, ST_BLO, ST_BHI, ST_TLO, ST_THI
  } ld_state_e;

  typedef enum logic [2:0] {
    LD_OK             = 3'd0,
    LD_INIT_START_TMO = 3'd1,
    LD_INIT_CLEAR_TMO = 3'd2,
    LD_CRC_ERR        = 3'd3,
    LD_DONE_TMO       = 3'd4,
    LD_UNSUPPORTED    = 3'd5
  } ld_status_e;
endpackage

// File: rtl/cfg_ld_tick.sv
// Phase timer for the configuration clock: one tick every div+1 enabled cycles.
module cfg_ld_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == div);

  always_comb begin
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cfg_ld_timer.sv
// Wait bound: expires in the LIMIT-th enabled cycle after a clear.
module cfg_ld_timer #(
  parameter int LIMIT = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt_q, cnt_d;

  assign expired = en && (cnt_q == W'(LIMIT - 1));

  always_comb begin
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
    else         cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cfg_ld_shift.sv
// MSB-first byte serialiser with a remaining-bit counter.
module cfg_ld_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [BYTE_W-1:0] din,
  output logic              msb,
  output logic              last
);
  localparam int IW = $clog2(BYTE_W);
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [IW-1:0]     idx_q, idx_d;

  assign msb  = sh_q[BYTE_W-1];
  assign last = (idx_q == '0);

  always_comb begin
    sh_d  = sh_q;
    idx_d = idx_q;
    if (load) begin
      sh_d  = din;
      idx_d = IW'(BYTE_W - 1);
    end else if (shift) begin
      sh_d  = {sh_q[BYTE_W-2:0], 1'b1};
      idx_d = idx_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      idx_q <= '0;
    end else begin
      sh_q  <= sh_d;
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_ld_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int CNT_W   = 16,
  parameter int BYTE_W  = 8,
  parameter int TMO_CYC = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_load,
  input  logic              cmd_readback,
  input  logic [CNT_W-1:0]  load_len,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              s_valid,
  input  logic [BYTE_W-1:0] s_data,
  output logic              s_ready,
  output logic              cfg_prog_n,
  output logic              cfg_cclk,
  output logic              cfg_din,
  input  logic              cfg_init_n,
  input  logic              cfg_done,
  output logic              busy,
  output logic              done_o,
  output logic [2:0]        status
);
  ld_state_e  st_q, st_d;
  ld_status_e status_q, code;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic done_q, fin;
  logic tick, tick_en, tmo, tmo_en, tmo_clr;
  logic sh_load, sh_shift, sh_msb, sh_last;
  logic crc_bad, in_trail, in_bit;

  assign in_bit   = (st_q == ST_BLO) || (st_q == ST_BHI);
  assign in_trail = (st_q == ST_TLO) || (st_q == ST_THI);
  assign tick_en  = in_bit || in_trail;
  assign tmo_en   = (st_q == ST_PROG) || (st_q == ST_REL) || in_trail;
  assign tmo_clr  = (st_d != st_q) && !in_trail;
  assign crc_bad  = !cfg_init_n && !cfg_done;

  cfg_ld_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(tick_en), .div(half_div), .tick(tick)
  );

  cfg_ld_timer #(.LIMIT(TMO_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmo_clr), .en(tmo_en), .expired(tmo)
  );

  cfg_ld_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .shift(sh_shift),
    .din(s_data), .msb(sh_msb), .last(sh_last)
  );

  // Next-state logic
  always_comb begin
    st_d     = st_q;
    rem_d    = rem_q;
    fin      = 1'b0;
    code     = LD_OK;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_load) begin
          st_d  = ST_PROG;
          rem_d = load_len;
        end else if (cmd_readback) begin
          fin  = 1'b1;
          code = LD_UNSUPPORTED;
        end
      end
      ST_PROG: begin
        if (!cfg_init_n) st_d = ST_REL;
        else if (tmo) begin fin = 1'b1; code = LD_INIT_START_TMO; end
      end
      ST_REL: begin
        if (cfg_init_n) st_d = (rem_q == '0) ? ST_TLO : ST_FETCH;
        else if (tmo) begin fin = 1'b1; code = LD_INIT_CLEAR_TMO; end
      end
      ST_FETCH: begin
        if (crc_bad) begin
          fin  = 1'b1;
          code = LD_CRC_ERR;
        end else if (s_valid) begin
          sh_load = 1'b1;
          rem_d   = rem_q - 1'b1;
          st_d    = ST_BLO;
        end
      end
      ST_BLO: if (tick) st_d = ST_BHI;
      ST_BHI: begin
        if (tick) begin
          if (sh_last) st_d = (rem_q == '0) ? ST_TLO : ST_FETCH;
          else begin
            sh_shift = 1'b1;
            st_d     = ST_BLO;
          end
        end
      end
      ST_TLO: begin
        if (cfg_done) fin = 1'b1;
        else if (tmo) begin fin = 1'b1; code = LD_DONE_TMO; end
        else if (tick) st_d = ST_THI;
      end
      ST_THI: begin
        if (tmo) begin fin = 1'b1; code = LD_DONE_TMO; end
        else if (tick) st_d = ST_TLO;
      end
      default: st_d = ST_IDLE;
    endcase
    if (fin) st_d = ST_IDLE;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      rem_q    <= '0;
      done_q   <= 1'b0;
      status_q <= LD_OK;
    end else begin
      st_q   <= st_d;
      rem_q  <= rem_d;
      done_q <= fin;
      if (fin) status_q <= code;
    end
  end

  assign s_ready    = (st_q == ST_FETCH) && !crc_bad;
  assign cfg_prog_n = (st_q != ST_PROG);
  assign cfg_cclk   = (st_q == ST_BHI) || (st_q == ST_THI);
  assign cfg_din    = in_bit ? sh_msb : 1'b1;
  assign busy       = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign status     = status_q;
endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_prog_n,
  input logic       cfg_cclk,
  input logic       cfg_din,
  input logic       cfg_init_n,
  input logic       cfg_done,
  input logic       s_ready,
  input logic       busy,
  input logic       done_o,
  input logic [2:0] status
);
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cfg_prog_n && !cfg_cclk && cfg_din && !s_ready)); // R1
  AST_NO_CLK_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_prog_n |-> !cfg_cclk); // R3
  AST_DIN_STABLE_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cclk && $past(cfg_cclk)) |-> $stable(cfg_din)); // R4
  AST_CRC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status == 3'd3) |-> $past(!cfg_init_n && !cfg_done)); // R5
  AST_OK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status == 3'd0) |-> $past(cfg_done)); // R6
  AST_SINGLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_READY_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !cfg_cclk); // R10
endmodule

bind cfg_serial_loader cfg_serial_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_prog_n(cfg_prog_n), .cfg_cclk(cfg_cclk),
  .cfg_din(cfg_din), .cfg_init_n(cfg_init_n), .cfg_done(cfg_done),
  .s_ready(s_ready), .busy(busy), .done_o(done_o), .status(status)
);

// File: tb/cfg_serial_loader_bench.sv
module cfg_serial_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 300;

  logic clk, rst_n, cmd_load, cmd_readback, s_valid, s_ready;
  logic [7:0] load_len, s_data;
  logic [3:0] half_div;
  logic prog_n, cclk, din, init_n, done_dev, busy, done_o;
  logic [2:0] status;

  cfg_serial_loader #(.DIV_W(4), .CNT_W(8), .BYTE_W(8), .TMO_CYC(TMO)) u_cfg_serial_loader (
    .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_readback(cmd_readback),
    .load_len(load_len), .half_div(half_div), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .cfg_prog_n(prog_n), .cfg_cclk(cclk), .cfg_din(din),
    .cfg_init_n(init_n), .cfg_done(done_dev), .busy(busy), .done_o(done_o),
    .status(status)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard queues: expected bytes at the device and bytes to feed
  logic [7:0] exp_q[$];
  logic [7:0] feed_q[$];
  bit took = 0;

  // device model knobs and observations
  bit m_start_ok, m_clear_ok, m_done_ok, crc_fired;
  int m_crc_after;
  int rx_bits, rx_bytes, trail_cnt, rises, hi_run, last_hi, prog_low, done_pulses;
  logic [7:0] rx_sh;
  logic cclk_prev;

  // stream driver
  always @(negedge clk) begin
    if (took && feed_q.size() > 0) void'(feed_q.pop_front());
    s_valid = (feed_q.size() > 0);
    s_data  = s_valid ? feed_q[0] : 8'h00;
    took    = s_valid && s_ready;
  end

  // device model and monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      init_n = 1'b1; done_dev = 1'b0; cclk_prev = 1'b0;
    end else begin
      if (!prog_n) begin
        prog_low++;
        init_n = m_start_ok ? 1'b0 : 1'b1;
        done_dev = 1'b0; rx_bits = 0; rx_bytes = 0; trail_cnt = 0; crc_fired = 0;
      end else if (!init_n && m_clear_ok && !crc_fired) init_n = 1'b1;
      if (cclk && !cclk_prev) begin
        rises++;
        if (exp_q.size() > 0) begin
          rx_sh = {rx_sh[6:0], din};
          rx_bits++;
          if (rx_bits % 8 == 0) begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(rx_sh == e, "R4 byte", rx_sh, e);
            rx_bytes++;
            if (rx_bytes == m_crc_after) begin init_n = 1'b0; crc_fired = 1; end
          end
        end else begin
          check(din == 1'b1, "R6 trail din", din, 1);
          trail_cnt++;
          if (m_done_ok && trail_cnt >= 3) done_dev = 1'b1;
        end
      end
      if (cclk) hi_run++;
      else begin
        if (cclk_prev) last_hi = hi_run;
        hi_run = 0;
      end
      if (done_o) done_pulses++;
      cclk_prev = cclk;
    end
  end

  task automatic set_model(input bit so, input bit co, input bit dn, input int crc);
    m_start_ok = so; m_clear_ok = co; m_done_ok = dn; m_crc_after = crc;
  endtask

  task automatic push_byte(input logic [7:0] b);
    exp_q.push_back(b);
    feed_q.push_back(b);
  endtask

  // issue a command, wait for completion, check status and pulse count
  task automatic run_cmd(input bit rb, input int len, input int div,
                         input int exp_st, input string req);
    int n;
    done_pulses = 0; rises = 0; prog_low = 0; trail_cnt = 0; last_hi = 0;
    load_len = 8'(len); half_div = 4'(div);
    @(negedge clk);
    if (rb) cmd_readback = 1'b1; else cmd_load = 1'b1;
    @(negedge clk);
    cmd_load = 1'b0; cmd_readback = 1'b0;
    if (!rb) check(busy == 1'b1, "R8 busy", busy, 1);
    n = 0;
    while (!done_o && n < 5000) begin @(negedge clk); n++; end
    check(status == 3'(exp_st), req, status, exp_st);
    repeat (4) @(negedge clk);
    check(done_pulses == 1, "R8 pulses", done_pulses, 1);
    check(busy == 1'b0, "R1 idle after", busy, 0);
  endtask

  task automatic flush();
    exp_q.delete();
    feed_q.delete();
  endtask

  initial begin
    rst_n = 1'b0; cmd_load = 1'b0; cmd_readback = 1'b0;
    load_len = '0; half_div = '0;
    set_model(1, 1, 1, -1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(prog_n == 1 && cclk == 0 && din == 1 && busy == 0 && done_o == 0,
          "R1 reset", {prog_n, cclk, din, busy, done_o}, 5'b10100);
    check(s_ready == 1'b0, "R10 idle ready", s_ready, 0);

    // normal load, three bytes, div 1
    push_byte(8'hA5); push_byte(8'h3C); push_byte(8'h81);
    run_cmd(0, 3, 1, 0, "R6 ok status");
    check(exp_q.size() == 0, "R4 all bytes", exp_q.size(), 0);
    check(trail_cnt >= 3, "R6 trailing pulses", trail_cnt, 3);
    check(prog_low > 0, "R2 program asserted", prog_low, 1);
    flush();

    // phase length with div 2
    push_byte(8'h5A); push_byte(8'hF0);
    run_cmd(0, 2, 2, 0, "R6 ok status div2");
    check(last_hi == 3, "R4 phase length", last_hi, 3);
    check(rises == 16 + trail_cnt, "R4 edge count", rises, 16 + trail_cnt);
    flush();

    // zero-length load
    run_cmd(0, 0, 0, 0, "R9 zero length");
    check(rises == trail_cnt && trail_cnt >= 3, "R9 only trail", rises, trail_cnt);
    flush();

    // init never enters
    set_model(0, 1, 1, -1);
    push_byte(8'h11);
    run_cmd(0, 1, 0, 1, "R2 init start timeout");
    check(rises == 0, "R2 no clocks", rises, 0);
    flush();

    // init never clears
    set_model(1, 0, 1, -1);
    push_byte(8'h22);
    run_cmd(0, 1, 0, 2, "R3 init clear timeout");
    check(rises == 0, "R3 no clocks", rises, 0);
    flush();

    // CRC error after first byte
    set_model(1, 1, 1, 1);
    push_byte(8'hC3); push_byte(8'h99); push_byte(8'h77);
    run_cmd(0, 3, 1, 3, "R5 crc status");
    check(rx_bytes == 1 && rises == 8, "R5 stop after byte", rises, 8);
    flush();

    // done never rises
    set_model(1, 1, 0, -1);
    push_byte(8'h0F);
    run_cmd(0, 1, 0, 4, "R6 done timeout");
    flush();

    // readback refused
    set_model(1, 1, 1, -1);
    run_cmd(1, 0, 0, 5, "R7 readback status");
    check(prog_low == 0 && rises == 0, "R7 pins idle", prog_low + rises, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule